// File: doc/BRIEF.md
# Charge-Transfer Touch Acquisition Controller

This block sequences capacitive touch measurements for up to eight groups of four IOs. Software marks each IO as a channel electrode, a shield or a sampling-capacitor pin through three 32-bit masks. A group takes part in an acquisition when any bit of its four-bit slice of the channel mask is set. After a launch the block repeats charge-transfer pulses. Each pulse has a charge phase, during which channel and shield IOs of the groups still running are driven high, and then a transfer phase. At the end of every transfer phase, each running group's 16-bit pulse counter advances. A group stops, and its counter freezes, once its comparator input is seen high at that point.

An acquisition ends when every enabled group has stopped, which sets the end flag. It also ends when a group reaches the programmed maximum count first, which sets both the end flag and the error flag. Software clears the flags by writing ones to a clear register. Two enables gate them onto one interrupt line. A launch comes either from writing the start bit from 0 to 1, or, in sync mode, from an edge of the synchronised `sync_in` pin of the chosen polarity while the start bit is held. Clearing the start bit aborts a running acquisition. The register port is a plain single-cycle write strobe with a combinational read. It carries no stream data, so it has no valid/ready handshake and no back-pressure.

Control word fields: [3:0] charge length−1, [7:4] transfer length−1, [10:8] prescale code p, [13:11] max-count code m, [14] spread enable, [15] spread clock /2, [22:16] spread deviation, [24] start, [25] sync mode, [26] sync on rising edge, [27] idle IOs float. Addresses: 0 control, 1 channel mask, 2 shield mask, 3 sampling mask, 4 interrupt enables ([0] end, [1] error), 5 status ([0] end flag, [1] error flag, [8+g] group g done, [16] busy), 6 flag clear ([0] end, [1] error), 8+g count of group g.

Top module: `tsc_acq_top`

## Requirements
- R1: Group g is enabled when any of channel-mask bits 4g..4g+3 is set. A disabled group's count stays 0 and its status bit stays 0, whatever its threshold input does.
- R2: With divider d = 2^p, the charge phase lasts (H+1)·d clock cycles and the transfer phase (L+1)·d cycles. The first charge phase starts in the cycle after the launching clock edge.
- R3: When the transfer length is 1 (L=0), p is raised to at least 2. When it is 2 (L=1), p is raised to at least 1. The prescale field reads back the effective code, so the reset value of the control word reads 0x200.
- R4: A running group's count is the number of transfer phases completed up to and including the first one at whose end its threshold input is high. The count then stays frozen until the next launch.
- R5: A launch clears all group status bits and counts. A group's status bit sets when it stops on its threshold.
- R6: When all enabled groups have stopped, busy falls and the end flag sets in the same cycle. The error flag stays 0.
- R7: If a running group completes its transfer phase with the threshold low and its count reaches M = 256·2^m − 1, the acquisition ends. Both flags set, that group's count equals M and its status stays 0.
- R8: Writing to the clear register clears only the flags whose bits are 1.
- R9: irq is high exactly when (end flag and enable bit 0) or (error flag and enable bit 1).
- R10: Writing the start bit as 0 during an acquisition stops it on the next edge without setting any flag.
- R11: In sync mode, a start-bit write does not launch. A synchronised edge of sync_in of the selected polarity launches within four cycles, and an edge of the other polarity does not.
- R12: While idle, every IO named in any mask is driven low if the float bit is 0 and released if it is 1. While running, sampling IOs are released, and io_out is never high where io_oe is low.
- R13: With spread enabled, each charge phase is lengthened by k·s cycles, with k ≤ deviation from a pseudo-random sequence and s = 2 when the /2 bit is set (else 1). Counts are unaffected.
- R14: After reset: no flags, busy and irq low, all IOs released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| sync_in | input | 1 | External acquisition trigger |
| thr_in | input | GROUPS | Per-group comparator threshold reached |
| io_oe | output | 4·GROUPS | IO output enable |
| io_out | output | 4·GROUPS | IO output level |
| irq | output | 1 | Interrupt request |
| busy | output | 1 | Acquisition in progress |

## Verification
On every cycle the checker enforces the following rules. A rising end flag coincides with busy falling, and an error flag never sets alone. Status bits are clear on launch, counts never exceed the maximum, counts hold still while idle, io_out never rises without io_oe, and irq never fires without a flag. Exact phase lengths, the counts reached for given threshold timings, prescaler forcing, sync polarity selection, abort and the spread-spectrum stretch depend on the stimulus. They are shown only by the bench's scenarios, where a behavioural pulse-timing model is compared with busy and the IO pins every cycle.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  localparam int IO_PER_GRP = 4;

  localparam logic [3:0] A_CTRL = 4'd0;
  localparam logic [3:0] A_CHM  = 4'd1;
  localparam logic [3:0] A_SHM  = 4'd2;
  localparam logic [3:0] A_SMM  = 4'd3;
  localparam logic [3:0] A_IEN  = 4'd4;
  localparam logic [3:0] A_STAT = 4'd5;
  localparam logic [3:0] A_CLR  = 4'd6;

  typedef struct packed {
    logic [3:0] spare;
    logic       io_float;
    logic       sync_rise;
    logic       sync_mode;
    logic       start;
    logic       spare1;
    logic [6:0] ss_dev;
    logic       ss_div2;
    logic       ss_en;
    logic [2:0] max_code;
    logic [2:0] psc;
    logic [3:0] lo_m1;
    logic [3:0] hi_m1;
  } ctrl_t;

  // Short transfer phases need a slower pulse clock
  function automatic logic [2:0] eff_psc(input logic [3:0] lo_m1, input logic [2:0] code);
    if (lo_m1 == 4'd0 && code < 3'd2) return 3'd2;
    if (lo_m1 == 4'd1 && code < 3'd1) return 3'd1;
    return code;
  endfunction
endpackage

// File: rtl/tsc_pulse_gen.sv
module tsc_pulse_gen #(
  parameter int TMR_W = 13
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       launch,
  input  logic [3:0] hi_m1,
  input  logic [3:0] lo_m1,
  input  logic [2:0] psc,
  input  logic       ss_en,
  input  logic       ss_div2,
  input  logic [6:0] ss_dev,
  output logic       phase_hi,
  output logic       xfer_end
);
  localparam logic [15:0] SEED = 16'hACE1;
  localparam logic [15:0] TAPS = 16'hB400;

  logic [TMR_W-1:0] tmr, div_w, hi_dur, lo_dur, ss_add;
  logic [15:0]      lfsr, lfsr_nxt;
  logic [7:0]       ss_k;

  assign div_w    = TMR_W'(1) << psc;
  assign ss_k     = lfsr[7:0] % (8'(ss_dev) + 8'd1);
  assign ss_add   = ss_en ? (ss_div2 ? TMR_W'(ss_k) << 1 : TMR_W'(ss_k)) : '0;
  assign hi_dur   = (TMR_W'(hi_m1) + TMR_W'(1)) * div_w + ss_add;
  assign lo_dur   = (TMR_W'(lo_m1) + TMR_W'(1)) * div_w;
  assign lfsr_nxt = {1'b0, lfsr[15:1]} ^ (lfsr[0] ? TAPS : 16'h0);
  assign xfer_end = run && !phase_hi && (tmr == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr      <= '0;
      phase_hi <= 1'b0;
      lfsr     <= SEED;
    end else if (launch || (run && tmr == '0 && !phase_hi)) begin
      phase_hi <= 1'b1;
      tmr      <= hi_dur - TMR_W'(1);
      lfsr     <= lfsr_nxt;
    end else if (run && tmr == '0) begin
      phase_hi <= 1'b0;
      tmr      <= lo_dur - TMR_W'(1);
    end else if (run) begin
      tmr <= tmr - TMR_W'(1);
    end
  end
endmodule

// File: rtl/tsc_grp_cnt.sv
module tsc_grp_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  logic             en,
  input  logic             thr,
  input  logic [CNT_W-1:0] maxc,
  output logic [CNT_W-1:0] cnt,
  output logic             done,
  output logic             hit_max
);
  logic             live;
  logic [CNT_W-1:0] inc;

  assign live    = step && en && !done;
  assign inc     = cnt + CNT_W'(1);
  assign hit_max = live && !thr && (inc >= maxc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (clear) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (live) begin
      if (cnt < maxc) cnt <= inc;
      if (thr) done <= 1'b1;
    end
  end
endmodule

// File: rtl/tsc_acq_top.sv
module tsc_acq_top
  import tsc_pkg::*;
#(
  parameter int GROUPS = 8,
  parameter int CNT_W  = 16,
  parameter int TMR_W  = 13
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         bus_wr,
  input  logic [3:0]                   bus_addr,
  input  logic [31:0]                  bus_wdata,
  output logic [31:0]                  bus_rdata,
  input  logic                         sync_in,
  input  logic [GROUPS-1:0]            thr_in,
  output logic [IO_PER_GRP*GROUPS-1:0] io_oe,
  output logic [IO_PER_GRP*GROUPS-1:0] io_out,
  output logic                         irq,
  output logic                         busy
);
  localparam int IO_W = IO_PER_GRP * GROUPS;

  ctrl_t            ctrl_q, ctrl_d;
  logic [IO_W-1:0]  ch_mask, sh_mask, smp_mask;
  logic [1:0]       ien;
  logic             end_flag, err_flag;
  logic             s_meta, s_sync, s_prev, sync_edge;
  logic             wr_ctrl, launch, abort, step, phase_hi, xfer_end;
  logic             any_err, all_fin;
  logic [2:0]       psc_eff;
  logic [CNT_W-1:0] maxc;
  logic [GROUPS-1:0] grp_en, grp_done, grp_hit, grp_fin, grp_act;
  logic [CNT_W-1:0]  cnt [GROUPS];
  logic [GROUPS*CNT_W-1:0] cnt_flat;

  assign wr_ctrl   = bus_wr && bus_addr == A_CTRL;
  assign ctrl_d    = wr_ctrl ? ctrl_t'(bus_wdata) : ctrl_q;
  assign psc_eff   = eff_psc(ctrl_d.lo_m1, ctrl_d.psc);
  assign maxc      = (CNT_W'(256) << ctrl_q.max_code) - CNT_W'(1);
  assign sync_edge = ctrl_q.sync_rise ? (s_sync && !s_prev) : (!s_sync && s_prev);
  assign launch    = !busy && ((wr_ctrl && ctrl_d.start && !ctrl_q.start && !ctrl_d.sync_mode)
                               || (ctrl_q.start && ctrl_q.sync_mode && sync_edge));
  assign abort     = busy && wr_ctrl && !ctrl_d.start;
  assign step      = busy && xfer_end;
  assign any_err   = |grp_hit;
  assign all_fin   = &grp_fin;
  assign irq       = (end_flag && ien[0]) || (err_flag && ien[1]);

  tsc_pulse_gen #(.TMR_W(TMR_W)) u_pgen (
    .clk(clk), .rst_n(rst_n), .run(busy), .launch(launch),
    .hi_m1(ctrl_d.hi_m1), .lo_m1(ctrl_d.lo_m1), .psc(psc_eff),
    .ss_en(ctrl_d.ss_en), .ss_div2(ctrl_d.ss_div2), .ss_dev(ctrl_d.ss_dev),
    .phase_hi(phase_hi), .xfer_end(xfer_end)
  );

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    assign grp_en[g]  = |ch_mask[IO_PER_GRP*g +: IO_PER_GRP];
    assign grp_fin[g] = !grp_en[g] || grp_done[g] || thr_in[g];
    assign grp_act[g] = busy && grp_en[g] && !grp_done[g];
    assign cnt_flat[g*CNT_W +: CNT_W] = cnt[g];
    tsc_grp_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clear(launch), .step(step),
      .en(grp_en[g]), .thr(thr_in[g]), .maxc(maxc),
      .cnt(cnt[g]), .done(grp_done[g]), .hit_max(grp_hit[g])
    );
  end

  for (genvar j = 0; j < IO_W; j++) begin : g_io
    logic drv;
    assign drv = ch_mask[j] || sh_mask[j];
    always_comb begin
      if (grp_act[j/IO_PER_GRP]) begin
        io_oe[j]  = drv;
        io_out[j] = drv && phase_hi;
      end else begin
        io_oe[j]  = !ctrl_q.io_float && (drv || smp_mask[j]);
        io_out[j] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      ch_mask  <= '0;
      sh_mask  <= '0;
      smp_mask <= '0;
      ien      <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_CTRL:  ctrl_q   <= ctrl_d;
        A_CHM:   ch_mask  <= bus_wdata[IO_W-1:0];
        A_SHM:   sh_mask  <= bus_wdata[IO_W-1:0];
        A_SMM:   smp_mask <= bus_wdata[IO_W-1:0];
        A_IEN:   ien      <= bus_wdata[1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {s_meta, s_sync, s_prev} <= '0;
      busy     <= 1'b0;
      end_flag <= 1'b0;
      err_flag <= 1'b0;
    end else begin
      {s_meta, s_sync, s_prev} <= {sync_in, s_meta, s_sync};
      if (bus_wr && bus_addr == A_CLR) begin
        if (bus_wdata[0]) end_flag <= 1'b0;
        if (bus_wdata[1]) err_flag <= 1'b0;
      end
      if (launch) begin
        busy <= 1'b1;
      end else if (abort) begin
        busy <= 1'b0;
      end else if (step && (any_err || all_fin)) begin
        busy     <= 1'b0;
        end_flag <= 1'b1;
        if (any_err) err_flag <= 1'b1;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr[3]) begin
      if (int'(bus_addr[2:0]) < GROUPS) bus_rdata = 32'(cnt[bus_addr[2:0]]);
    end else begin
      case (bus_addr)
        A_CTRL: begin
          bus_rdata       = ctrl_q;
          bus_rdata[10:8] = eff_psc(ctrl_q.lo_m1, ctrl_q.psc);
        end
        A_CHM:  bus_rdata = 32'(ch_mask);
        A_SHM:  bus_rdata = 32'(sh_mask);
        A_SMM:  bus_rdata = 32'(smp_mask);
        A_IEN:  bus_rdata = 32'(ien);
        A_STAT: begin
          bus_rdata[0]           = end_flag;
          bus_rdata[1]           = err_flag;
          bus_rdata[8 +: GROUPS] = grp_done;
          bus_rdata[16]          = busy;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tsc_acq_chk.sv
module tsc_acq_chk #(
  parameter int GROUPS = 8,
  parameter int CNT_W  = 16,
  parameter int IO_W   = 32
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    busy,
  input logic                    irq,
  input logic                    end_flag,
  input logic                    err_flag,
  input logic [GROUPS-1:0]       grp_done,
  input logic [GROUPS*CNT_W-1:0] cnt_flat,
  input logic [CNT_W-1:0]        maxc,
  input logic [IO_W-1:0]         io_oe,
  input logic [IO_W-1:0]         io_out
);
  assert_end_with_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(end_flag) |-> $fell(busy));

  assert_err_implies_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flag) |-> end_flag);

  assert_status_clear_on_launch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> grp_done == '0);

  assert_counts_frozen_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> $stable(cnt_flat));

  assert_out_needs_oe_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (io_out & ~io_oe) == '0);

  assert_irq_has_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (end_flag || err_flag));

  for (genvar g = 0; g < GROUPS; g++) begin : g_chk
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> cnt_flat[g*CNT_W +: CNT_W] <= maxc);
    assert_done_while_running_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(grp_done[g]) |-> $past(busy));
  end
endmodule

bind tsc_acq_top tsc_acq_chk #(.GROUPS(GROUPS), .CNT_W(CNT_W), .IO_W(IO_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .irq(irq), .end_flag(end_flag),
  .err_flag(err_flag), .grp_done(grp_done), .cnt_flat(cnt_flat), .maxc(maxc),
  .io_oe(io_oe), .io_out(io_out)
);

// File: tb/tb_tsc_acq_top.sv
module tb_tsc_acq_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sync_in = 1'b0;
  logic [7:0]  thr = '0;
  logic [31:0] io_oe, io_out;
  logic        irq, busy;
  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  tsc_acq_top dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sync_in(sync_in),
    .thr_in(thr), .io_oe(io_oe), .io_out(io_out), .irq(irq), .busy(busy)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output int d);
    @(negedge clk);
    bus_addr = a;
    #1 d = int'(bus_rdata);
  endtask

  function automatic logic [31:0] mk(input int hm1, lm1, pc, input bit ss, ss2,
                                     input int dev, input bit st, sm, sr, fl);
    return {4'h0, fl, sr, sm, st, 1'b0, 7'(dev), ss2, ss, 3'd0, 3'(pc), 4'(lm1), 4'(hm1)};
  endfunction

  // Behavioural pulse-timing model, compared every cycle
  task automatic run_model(input string req, input int hm1, lm1, pc, d, en_mask,
                           input int kv[8]);
    int h, l, p, tend, kmax, v, stat;
    bit err;
    h = hm1 + 1; l = lm1 + 1; p = (h + l) * d;
    kmax = 0; err = 0;
    for (int g = 0; g < 8; g++)
      if (en_mask[g]) begin
        if (kv[g] > 255) err = 1;
        else if (kv[g] > kmax) kmax = kv[g];
      end
    tend = err ? 255 * p : kmax * p;
    wr(4'd0, mk(hm1, lm1, pc, 0, 0, 0, 0, 0, 0, 0));
    wr(4'd6, 32'h3);
    thr = '0;
    wr(4'd0, mk(hm1, lm1, pc, 0, 0, 0, 1, 0, 0, 0));
    for (int t = 0; t <= tend + 1; t++) begin
      int k, w;
      k = t / p; w = t % p;
      for (int g = 0; g < 8; g++) thr[g] = (k + 1 >= kv[g]);
      chk({req, " R6 busy"}, int'(busy), int'(t < tend));
      chk({req, " R2 charge pin"}, int'(io_out[0]),
          int'(t < tend && en_mask[0] && k < kv[0] && w < h * d));
      if (t < tend) chk({req, " R12 sample pin released"}, int'(io_oe[1]), 0);
      @(negedge clk);
    end
    thr = '0;
    stat = 1 | (int'(err) << 1);
    for (int g = 0; g < 8; g++) begin
      int e;
      e = en_mask[g] ? (kv[g] > 255 ? 255 : kv[g]) : 0;
      rd(4'(8 + g), v);
      chk({req, " R4 R1 R7 count"}, v, e);
      if (en_mask[g] && kv[g] <= 255) stat |= 1 << (8 + g);
    end
    rd(4'd5, v);
    chk({req, " R5 status"}, v, stat);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int v, kv[8], hl, mx, edges, cyc;
    bit prev, seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R14 reset state
    rd(4'd5, v);  chk("R14 status", v, 0);
    chk("R14 irq", int'(irq), 0);
    chk("R14 io_oe", int'(io_oe), 0);
    rd(4'd0, v);  chk("R3 R14 ctrl readback", v, 32'h200);

    // Groups 0 and 2 (mask top bit of slice 2), group 1 not enabled
    wr(4'd1, 32'h0000_0801);
    wr(4'd2, 32'h0000_0004);
    wr(4'd3, 32'h0000_0102);
    kv = '{5, 1, 3, 1, 1, 1, 1, 1};
    run_model("basic", 1, 2, 1, 2, 8'h05, kv);
    chk("R12 idle drive low", int'(io_oe), 32'h907);
    chk("R9 irq masked", int'(irq), 0);
    wr(4'd4, 32'h1);
    chk("R9 irq end", int'(irq), 1);
    wr(4'd6, 32'h2);
    rd(4'd5, v); chk("R8 clear err only", v & 3, 1);
    wr(4'd6, 32'h1);
    rd(4'd5, v); chk("R8 clear end", v & 3, 0);
    chk("R9 irq cleared", int'(irq), 0);

    // Prescaler forcing
    wr(4'd1, 32'h1);
    kv = '{4, 1, 1, 1, 1, 1, 1, 1};
    run_model("forced4", 0, 0, 0, 4, 8'h01, kv);
    rd(4'd0, v); chk("R3 psc forced 4", (v >> 8) & 7, 2);
    kv = '{3, 1, 1, 1, 1, 1, 1, 1};
    run_model("forced2", 2, 1, 0, 2, 8'h01, kv);
    rd(4'd0, v); chk("R3 psc forced 2", (v >> 8) & 7, 1);
    wr(4'd0, mk(0, 2, 0, 0, 0, 0, 0, 0, 0, 0));
    rd(4'd0, v); chk("R3 psc unforced", (v >> 8) & 7, 0);

    // Max count error
    wr(4'd4, 32'h2);
    kv = '{1000, 1, 1, 1, 1, 1, 1, 1};
    run_model("maxcnt", 0, 0, 0, 4, 8'h01, kv);
    chk("R7 R9 irq err", int'(irq), 1);
    wr(4'd4, 32'h3);

    // Abort
    wr(4'd0, mk(0, 0, 0, 0, 0, 0, 0, 0, 0, 0));
    wr(4'd6, 32'h3);
    wr(4'd0, mk(0, 0, 0, 0, 0, 0, 1, 0, 0, 0));
    repeat (20) @(negedge clk);
    chk("R10 running", int'(busy), 1);
    wr(4'd0, mk(0, 0, 0, 0, 0, 0, 0, 0, 0, 0));
    chk("R10 aborted", int'(busy), 0);
    rd(4'd5, v); chk("R10 no flags", v & 3, 0);
    chk("R10 irq", int'(irq), 0);

    // Sync launch
    thr = 8'hFF;
    wr(4'd0, mk(0, 0, 0, 0, 0, 0, 1, 1, 1, 0));
    repeat (4) @(negedge clk);
    chk("R11 no launch from start", int'(busy), 0);
    sync_in = 1'b1; seen = 0;
    for (int i = 0; i < 4; i++) begin @(negedge clk); if (busy) seen = 1; end
    chk("R11 rising launch", int'(seen), 1);
    repeat (20) @(negedge clk);
    wr(4'd0, mk(0, 0, 0, 0, 0, 0, 1, 1, 0, 0));
    sync_in = 1'b0; seen = 0;
    for (int i = 0; i < 4; i++) begin @(negedge clk); if (busy) seen = 1; end
    chk("R11 falling launch", int'(seen), 1);
    repeat (20) @(negedge clk);
    sync_in = 1'b1; seen = 0;
    for (int i = 0; i < 10; i++) begin @(negedge clk); if (busy) seen = 1; end
    chk("R11 wrong edge ignored", int'(seen), 0);
    thr = '0;

    // Spread spectrum
    wr(4'd0, mk(0, 0, 0, 1, 1, 7, 0, 0, 0, 0));
    wr(4'd6, 32'h3);
    wr(4'd0, mk(0, 0, 0, 1, 1, 7, 1, 0, 0, 0));
    edges = 0; hl = 0; mx = 0; cyc = 0; prev = 0;
    while (busy && cyc < 3000) begin
      if (io_out[0] && !prev) edges++;
      if (io_out[0]) hl++; else hl = 0;
      if (hl > mx) mx = hl;
      prev = io_out[0];
      thr[0] = (edges >= 20);
      cyc++;
      @(negedge clk);
    end
    thr = '0;
    rd(4'd8, v); chk("R13 count", v, 20);
    chk("R13 stretched", int'(mx > 4), 1);
    chk("R13 bounded", int'(mx <= 18), 1);
    chk("R13 duration", int'(cyc >= 160 && cyc <= 440), 1);

    // Float idle IOs
    wr(4'd0, mk(0, 0, 0, 0, 0, 0, 0, 0, 0, 1));
    chk("R12 idle float", int'(io_oe), 0);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule